// File: doc/BRIEF.md
# Single-Bank Read and Precharge Timing Controller

This block sits between a host and one bank of a low-power double-data-rate memory. It decides when the bank's activate, read and precharge commands may go out. The host offers one request at a time over a valid/ready handshake: open a row, read a column (optionally closing the row by itself afterwards), or close the row. The block drives at most one command per clock onto its command output. A clock with no command drives NOP. A request whose timing rule is not yet met is held by keeping ready low. A request that makes no sense for the bank's current state is consumed and answered with an error pulse.

The block also predicts the read return. For every read it raises a data-valid flag once per clock for each rising/falling beat pair, starting CAS latency clocks after the read command and carrying the column of the pair's first beat. A later read cuts the running burst short, and so does a precharge. A read with self-closing enabled arms an internal precharge. That precharge drives no command. It fires once half a burst length has passed since the read and the minimum row-active time since the activate has also passed, and it starts the precharge recovery window.

Top module: `sdr_bank_ctrl`

## Requirements
- R1: During and straight after reset, cmd_code is NOP (0), err_pulse and rd_valid are low, and an activate request (req_op 0) is ready at once.
- R2: After a precharge request to an open row is accepted in cycle p, an activate is not accepted before cycle p+TRP. req_ready stays low for it until then.
- R3: A precharge to an open row is not accepted before TRAS cycles after the accepting cycle of that row's activate.
- R4: After a read is accepted in cycle r, neither another read nor a precharge to the open row is accepted before cycle r+2.
- R5: A read with req_ap=1 accepted in cycle r, for a row activated in cycle a, closes the row internally in cycle f=max(r+BL/2, a+TRAS). No command appears on cmd_code for it, and the next activate is accepted no earlier than f+TRP.
- R6: A read that appears on cmd_code in cycle t yields BL/2 cycles of rd_valid starting in cycle t+CL. CL is 2 when cas3=0 and 3 when cas3=1, and cas3 is held steady while reads are in flight. rd_col reads n, n+2, n+4, ... (modulo 2^COL_W) from the read column n.
- R7: A precharge (explicit, or internal per R5) that takes effect on the bus in cycle q suppresses rd_valid in every cycle from q+CL on.
- R8: A read whose data starts while an earlier burst is still running ends that burst. From then on only the new read's pairs appear.
- R9: A read request while no row is open, an activate request while a row is open, or req_op 3 is accepted without a command. cmd_code stays NOP and err_pulse is high for one cycle, in the cycle after acceptance. The row state does not change.
- R10: An accepted request appears in the next cycle as exactly one command: activate 1, read 2, read with self-close 3, precharge 4. For activate and read, cmd_addr carries req_addr. Request codes are activate 0, read 1, precharge 2. Every other cycle drives NOP.
- R11: A precharge request while no row is open is accepted at once and restarts the TRP window from its accepting cycle.
- R12: While a self-closing precharge is pending, activate, read and precharge requests are stalled with req_ready low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cas3 | input | 1 | CAS latency select: 0 gives 2 clocks, 1 gives 3 clocks |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_op | input | 2 | Request kind: 0 activate, 1 read, 2 precharge, 3 illegal |
| req_ap | input | 1 | Read closes its row by itself |
| req_addr | input | AW | Row for activate, column in low COL_W bits for read |
| cmd_code | output | 3 | Command on the bus: 0 NOP, 1 activate, 2 read, 3 read with self-close, 4 precharge |
| cmd_addr | output | AW | Address sent with activate or read, zero otherwise |
| err_pulse | output | 1 | One-cycle pulse for a rejected request |
| rd_valid | output | 1 | A data pair is on the bus this cycle |
| rd_col | output | COL_W | Column of the first beat of the current pair |

## Verification
On every cycle, the assertions check the spacing rules between accepted commands. These are the row-active, recovery and read-gap windows. They also check that the internal close never fires early, that nothing is issued while a self-close is pending, and that a stalled or rejected request produces no command. What the data outputs do cannot be seen from those rules alone, and only the bench's scenarios show it. This covers the CAS-latency offset under both settings, column stepping with wrap-around, burst cut-off by a following read or by a precharge, and the exact cycle in which a deferred self-close lets the next activate through.

// File: rtl/sdr_bank_pkg.sv
package sdr_bank_pkg;

  typedef enum logic [1:0] {
    OP_ACT = 2'd0,
    OP_RD  = 2'd1,
    OP_PRE = 2'd2,
    OP_BAD = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_RDA = 3'd3,
    CMD_PRE = 3'd4
  } cmd_e;

  // Minimum spacing from a read to a following read or precharge.
  localparam int unsigned RD_SPACING = 2;

  // Number of clock-wide data pairs in one burst.
  function automatic int unsigned pairs_of(input int unsigned bl);
    return bl / 2;
  endfunction

  // Pipeline tap that launches data: CL-1 stages after the command register.
  function automatic int unsigned tap_of(input logic cl3);
    return cl3 ? 2 : 1;
  endfunction

endpackage

// File: rtl/sdr_dn_counter.sv
module sdr_dn_counter #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/sdr_bank_decide.sv
module sdr_bank_decide
  import sdr_bank_pkg::*;
(
  input  op_e  op,
  input  logic row_open,
  input  logic ap_pend,
  input  logic tras_zero,
  input  logic trp_zero,
  input  logic gap_zero,
  output logic can_issue,
  output logic reject
);
  always_comb begin
    can_issue = 1'b0;
    reject    = 1'b0;
    unique case (op)
      OP_ACT: if (!ap_pend) begin
        if (row_open) reject    = 1'b1;
        else          can_issue = trp_zero;
      end
      OP_RD: if (!ap_pend) begin
        if (!row_open) reject    = 1'b1;
        else           can_issue = gap_zero;
      end
      OP_PRE: if (!ap_pend) begin
        can_issue = row_open ? (tras_zero && gap_zero) : 1'b1;
      end
      default: reject = 1'b1;
    endcase
  end
endmodule

// File: rtl/sdr_read_model.sv
module sdr_read_model
  import sdr_bank_pkg::*;
#(
  parameter int COL_W = 10,
  parameter int BL    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cas3,
  input  logic             rd_launch,
  input  logic [COL_W-1:0] rd_col_in,
  input  logic             pre_evt,
  output logic             rd_valid,
  output logic [COL_W-1:0] rd_col
);
  localparam int PAIRS  = pairs_of(BL);
  localparam int PAIR_W = $clog2(PAIRS + 1);
  localparam int DEPTH  = 3;

  logic [DEPTH-1:0] l_vld;
  logic [DEPTH-1:0] p_vld;
  logic [COL_W-1:0] l_col [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      l_vld[0] <= 1'b0;
      p_vld[0] <= 1'b0;
      l_col[0] <= '0;
    end else begin
      l_vld[0] <= rd_launch;
      p_vld[0] <= pre_evt;
      l_col[0] <= rd_col_in;
    end
  end

  for (genvar g = 1; g < DEPTH; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        l_vld[g] <= 1'b0;
        p_vld[g] <= 1'b0;
        l_col[g] <= '0;
      end else begin
        l_vld[g] <= l_vld[g-1];
        p_vld[g] <= p_vld[g-1];
        l_col[g] <= l_col[g-1];
      end
    end
  end

  logic             start, kill;
  logic [COL_W-1:0] start_col;
  logic [PAIR_W-1:0] left;
  logic [COL_W-1:0] col_q;

  always_comb begin
    int unsigned t;
    t         = tap_of(cas3);
    start     = l_vld[t];
    kill      = p_vld[t];
    start_col = l_col[t];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left  <= '0;
      col_q <= '0;
    end else if (start) begin
      left  <= PAIR_W'(PAIRS);
      col_q <= start_col;
    end else if (kill) begin
      left  <= '0;
    end else if (left != '0) begin
      left  <= left - 1'b1;
      col_q <= col_q + COL_W'(2);
    end
  end

  assign rd_valid = (left != '0);
  assign rd_col   = col_q;
endmodule

// File: rtl/sdr_bank_ctrl.sv
module sdr_bank_ctrl
  import sdr_bank_pkg::*;
#(
  parameter int TRAS  = 7,
  parameter int TRP   = 3,
  parameter int BL    = 8,
  parameter int ROW_W = 13,
  parameter int COL_W = 10,
  parameter int AW    = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cas3,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_op,
  input  logic             req_ap,
  input  logic [AW-1:0]    req_addr,
  output logic [2:0]       cmd_code,
  output logic [AW-1:0]    cmd_addr,
  output logic             err_pulse,
  output logic             rd_valid,
  output logic [COL_W-1:0] rd_col
);
  localparam int PAIRS  = pairs_of(BL);
  localparam int TRAS_W = $clog2(TRAS + 1);
  localparam int TRP_W  = $clog2(TRP + 1);
  localparam int AP_W   = $clog2(PAIRS + 1);
  localparam int GAP_W  = 2;

  op_e  op;
  logic row_open, ap_pend;
  logic tras_zero, trp_zero, gap_zero, ap_zero;
  logic can_issue, reject;

  // Named internal events, used by the logic and the bound checker.
  logic issue, rej, act_go, rd_go, rd_ap_go, pre_go, ap_fire;

  assign op = op_e'(req_op);

  sdr_bank_decide u_decide (
    .op        (op),
    .row_open  (row_open),
    .ap_pend   (ap_pend),
    .tras_zero (tras_zero),
    .trp_zero  (trp_zero),
    .gap_zero  (gap_zero),
    .can_issue (can_issue),
    .reject    (reject)
  );

  assign req_ready = can_issue | reject;
  assign issue     = req_valid & can_issue;
  assign rej       = req_valid & reject;
  assign act_go    = issue & (op == OP_ACT);
  assign rd_go     = issue & (op == OP_RD);
  assign rd_ap_go  = rd_go & req_ap;
  assign pre_go    = issue & (op == OP_PRE);
  assign ap_fire   = ap_pend & ap_zero & tras_zero;

  sdr_dn_counter #(.W(TRAS_W)) u_tras (
    .clk(clk), .rst_n(rst_n), .load(act_go),
    .load_val(TRAS_W'(TRAS - 1)), .zero(tras_zero));

  sdr_dn_counter #(.W(TRP_W)) u_trp (
    .clk(clk), .rst_n(rst_n), .load(pre_go | ap_fire),
    .load_val(TRP_W'(TRP - 1)), .zero(trp_zero));

  sdr_dn_counter #(.W(GAP_W)) u_gap (
    .clk(clk), .rst_n(rst_n), .load(rd_go),
    .load_val(GAP_W'(RD_SPACING - 1)), .zero(gap_zero));

  sdr_dn_counter #(.W(AP_W)) u_ap (
    .clk(clk), .rst_n(rst_n), .load(rd_ap_go),
    .load_val(AP_W'(PAIRS - 1)), .zero(ap_zero));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row_open <= 1'b0;
      ap_pend  <= 1'b0;
    end else begin
      if (act_go)                row_open <= 1'b1;
      else if (pre_go | ap_fire) row_open <= 1'b0;
      if (rd_ap_go)              ap_pend  <= 1'b1;
      else if (ap_fire)          ap_pend  <= 1'b0;
    end
  end

  cmd_e cmd_d;
  always_comb begin
    cmd_d = CMD_NOP;
    if (act_go)        cmd_d = CMD_ACT;
    else if (rd_go)    cmd_d = req_ap ? CMD_RDA : CMD_RD;
    else if (pre_go)   cmd_d = CMD_PRE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_code  <= CMD_NOP;
      cmd_addr  <= '0;
      err_pulse <= 1'b0;
    end else begin
      cmd_code  <= cmd_d;
      cmd_addr  <= (act_go | rd_go) ? req_addr : '0;
      err_pulse <= rej;
    end
  end

  sdr_read_model #(.COL_W(COL_W), .BL(BL)) u_rdm (
    .clk       (clk),
    .rst_n     (rst_n),
    .cas3      (cas3),
    .rd_launch (rd_go),
    .rd_col_in (req_addr[COL_W-1:0]),
    .pre_evt   (pre_go | ap_fire),
    .rd_valid  (rd_valid),
    .rd_col    (rd_col)
  );
endmodule

// File: rtl/sdr_bank_ctrl_chk.sv
module sdr_bank_ctrl_chk
  import sdr_bank_pkg::*;
#(
  parameter int TRAS = 7,
  parameter int TRP  = 3,
  parameter int BL   = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic       act_go,
  input logic       rd_go,
  input logic       rd_ap_go,
  input logic       pre_go,
  input logic       ap_fire,
  input logic       rej,
  input logic [2:0] cmd_code,
  input logic       err_pulse
);
  localparam int PAIRS = pairs_of(BL);
  localparam int SA_W  = $clog2(TRAS + 1);
  localparam int SP_W  = $clog2(TRP + 1);
  localparam int SR_W  = 2;
  localparam int SD_W  = $clog2(PAIRS + 1);

  logic [SA_W-1:0] since_act;
  logic [SP_W-1:0] since_pre;
  logic [SR_W-1:0] since_rd;
  logic [SD_W-1:0] since_rda;
  logic            sh_open, sh_ap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_act <= '0;
      since_pre <= SP_W'(TRP);
      since_rd  <= SR_W'(RD_SPACING);
      since_rda <= '0;
      sh_open   <= 1'b0;
      sh_ap     <= 1'b0;
    end else begin
      if (act_go)                        since_act <= SA_W'(1);
      else if (since_act < SA_W'(TRAS))  since_act <= since_act + 1'b1;
      if (pre_go | ap_fire)              since_pre <= SP_W'(1);
      else if (since_pre < SP_W'(TRP))   since_pre <= since_pre + 1'b1;
      if (rd_go)                         since_rd  <= SR_W'(1);
      else if (since_rd < SR_W'(RD_SPACING)) since_rd <= since_rd + 1'b1;
      if (rd_ap_go)                      since_rda <= SD_W'(1);
      else if (since_rda < SD_W'(PAIRS)) since_rda <= since_rda + 1'b1;
      if (act_go)                        sh_open <= 1'b1;
      else if (pre_go | ap_fire)         sh_open <= 1'b0;
      if (rd_ap_go)                      sh_ap <= 1'b1;
      else if (ap_fire)                  sh_ap <= 1'b0;
    end
  end

  a_r2_act_after_trp: assert property (@(posedge clk) disable iff (!rst_n)
    act_go |-> since_pre >= SP_W'(TRP));

  a_r3_pre_after_tras: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_go && sh_open) |-> since_act >= SA_W'(TRAS));

  a_r4_read_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_go || (pre_go && sh_open)) |-> since_rd >= SR_W'(RD_SPACING));

  a_r5_ap_not_early: assert property (@(posedge clk) disable iff (!rst_n)
    ap_fire |-> (since_act >= SA_W'(TRAS)) && (since_rda >= SD_W'(PAIRS)));

  a_r5_ap_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (ap_fire && !act_go && !rd_go && !pre_go) |=> cmd_code == CMD_NOP);

  a_r9_reject_no_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    rej |=> (err_pulse && cmd_code == CMD_NOP));

  a_r10_stall_nop: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (cmd_code == CMD_NOP && !err_pulse));

  a_r12_hold_while_ap: assert property (@(posedge clk) disable iff (!rst_n)
    sh_ap |-> !(act_go || rd_go || pre_go));
endmodule

bind sdr_bank_ctrl sdr_bank_ctrl_chk #(
  .TRAS(TRAS), .TRP(TRP), .BL(BL)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .act_go    (act_go),
  .rd_go     (rd_go),
  .rd_ap_go  (rd_ap_go),
  .pre_go    (pre_go),
  .ap_fire   (ap_fire),
  .rej       (rej),
  .cmd_code  (cmd_code),
  .err_pulse (err_pulse)
);

// File: tb/sdr_bank_ctrl_tb_top.sv
module sdr_bank_ctrl_tb_top;
  localparam int TRAS  = 7;
  localparam int TRP   = 3;
  localparam int BL    = 8;
  localparam int ROW_W = 13;
  localparam int COL_W = 10;
  localparam int AW    = 13;
  localparam int NPAIR = BL / 2;
  localparam int RUN   = 12000;
  localparam int ND    = 14;

  logic clk = 1'b0, rst_n = 1'b0, cas3 = 1'b0;
  logic req_valid = 1'b0, req_ap = 1'b0;
  logic [1:0] req_op = 2'd0;
  logic [AW-1:0] req_addr = '0;
  logic req_ready, err_pulse, rd_valid;
  logic [2:0] cmd_code;
  logic [AW-1:0] cmd_addr;
  logic [COL_W-1:0] rd_col;

  sdr_bank_ctrl #(.TRAS(TRAS), .TRP(TRP), .BL(BL), .ROW_W(ROW_W), .COL_W(COL_W), .AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cas3(cas3), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_ap(req_ap), .req_addr(req_addr), .cmd_code(cmd_code),
    .cmd_addr(cmd_addr), .err_pulse(err_pulse), .rd_valid(rd_valid), .rd_col(rd_col));

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_tests = 0, n_fail = 0;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  // Reference state, kept in accepting-cycle timestamps.
  bit m_open = 0, m_ap = 0, trp_from_ap = 0;
  int m_f = 0, trp_at = 0, tras_at = 0, gap_at = 0, last_rd = -100;
  bit    ring_v [64];
  int    ring_c [64];
  string ring_t [64];
  int e_cmd = 0, e_addr = 0;
  bit e_err = 0;

  bit have = 0, h_ap = 0;
  int h_op = 0, h_addr = 0, held = 0, d_idx = 0;
  int d_op [ND], d_ap [ND], d_addr [ND];
  bit abort = 0, flipped = 0;

  function automatic int cl_now();
    return cas3 ? 3 : 2;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Expected ready per the requirement rules, with the tag of the rule in force.
  function automatic bit exp_ready(input int op, input int c, output string tag);
    if (op == 3) begin tag = "R9"; return 1; end
    if (m_ap) begin tag = "R12"; return 0; end
    case (op)
      0: if (m_open) begin tag = "R9"; return 1; end
         else begin tag = trp_from_ap ? "R5" : "R2"; return c >= trp_at; end
      1: if (!m_open) begin tag = "R9"; return 1; end
         else begin tag = "R4"; return c >= gap_at; end
      default: if (m_open) begin
                 tag = (c < tras_at) ? "R3" : "R4";
                 return (c >= tras_at) && (c >= gap_at);
               end else begin tag = "R11"; return 1; end
    endcase
  endfunction

  task automatic kill_from(input int start);
    for (int k = 0; k < NPAIR; k++) begin
      int s = (start + k) % 64;
      if (ring_v[s]) ring_t[s] = "R7";
      ring_v[s] = 0;
    end
  endtask

  task automatic step();
    int c, slot;
    string tag;
    bit r;
    @(negedge clk);
    c = cyc;
    chk("R10", "cmd_code", int'(cmd_code), e_cmd);
    chk("R10", "cmd_addr", int'(cmd_addr), e_addr);
    chk("R9", "err_pulse", int'(err_pulse), int'(e_err));
    slot = c % 64;
    chk(ring_t[slot], "rd_valid", int'(rd_valid), int'(ring_v[slot]));
    if (ring_v[slot]) chk("R6", "rd_col", int'(rd_col), ring_c[slot]);
    ring_v[slot] = 0;
    ring_t[slot] = "R6";

    if (m_ap && c > m_f) begin
      m_ap = 0; m_open = 0;
      trp_at = m_f + TRP; trp_from_ap = 1;
      kill_from(m_f + 1 + cl_now());
    end

    if (!have) begin
      if (d_idx < ND) begin
        h_op = d_op[d_idx]; h_ap = d_ap[d_idx][0]; h_addr = d_addr[d_idx];
        d_idx++; have = 1;
      end else if ((c % 1500) < 1470 && ($urandom % 100) < 70) begin
        int w = $urandom % 100;
        h_op = (w < 25) ? 0 : (w < 65) ? 1 : (w < 90) ? 2 : 3;
        h_ap = (($urandom % 100) < 35);
        h_addr = $urandom % (1 << AW);
        have = 1;
      end
    end
    if ((c % 1500) < 1470) flipped = 0;
    else if (!flipped && !have && !m_ap && (c - last_rd) > 20) begin
      cas3 = ~cas3; flipped = 1;
    end

    req_valid = have; req_op = 2'(h_op); req_ap = h_ap; req_addr = AW'(h_addr);
    #1;
    e_cmd = 0; e_addr = 0; e_err = 0;
    if (have) begin
      r = exp_ready(h_op, c, tag);
      chk(tag, "req_ready", int'(req_ready), int'(r));
      if (req_ready) begin
        if (h_op == 3 || (h_op == 0 && m_open) || (h_op == 1 && !m_open)) begin
          e_err = 1;   // R9 reject
        end else if (h_op == 0) begin
          e_cmd = 1; e_addr = h_addr;
          m_open = 1; tras_at = c + TRAS;
        end else if (h_op == 1) begin
          e_cmd = h_ap ? 3 : 2; e_addr = h_addr;
          gap_at = c + 2; last_rd = c;
          for (int k = 0; k < NPAIR; k++) begin
            int s = (c + 1 + cl_now() + k) % 64;
            ring_t[s] = ring_v[s] ? "R8" : "R6";
            ring_v[s] = 1;
            ring_c[s] = (h_addr + 2 * k) % (1 << COL_W);
          end
          if (h_ap) begin m_ap = 1; m_f = imax(c + NPAIR, tras_at); end
        end else begin
          e_cmd = 4;
          m_open = 0;
          trp_at = c + TRP; trp_from_ap = 0;
          kill_from(c + 1 + cl_now());
        end
        have = 0; held = 0;
      end else begin
        held++;
        if (held > 300) begin
          n_tests++; n_fail++;
          $display("FAIL R10 watchdog: request held %0d cycles, expected acceptance", held);
          abort = 1;
        end
      end
    end
  endtask

  initial begin
    // Directed corner sequence ahead of the random phase.
    d_op = '{0, 1, 0, 1, 1, 1, 1, 2, 2, 0, 0, 3, 2, 1};
    d_ap = '{0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0};
    d_addr = '{'h155, 'h3fc, 'h0aa, 'h040, 'h080, 'h0c0, 'h100, 0, 0, 'h1234, 'h0777, 0, 0, 'h010};
    for (int i = 0; i < 64; i++) begin ring_v[i] = 0; ring_c[i] = 0; ring_t[i] = "R6"; end
    void'($urandom(32'h5d0b_a11c));

    repeat (3) @(negedge clk);
    chk("R1", "cmd_code in reset", int'(cmd_code), 0);
    chk("R1", "rd_valid in reset", int'(rd_valid), 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "cmd_code after reset", int'(cmd_code), 0);
    chk("R1", "err_pulse after reset", int'(err_pulse), 0);
    chk("R1", "rd_valid after reset", int'(rd_valid), 0);
    req_op = 2'd0;
    #1;
    chk("R1", "req_ready for activate", int'(req_ready), 1);

    for (int i = 0; i < RUN && !abort; i++) step();

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(4 * 150000);
    n_tests++; n_fail++;
    $display("FAIL R10 global watchdog expired, expected run to finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule